// File: doc/BRIEF.md
# Serial Control Register Port

This block is the receiving end of a three-line serial control port. An external controller moves a data line, clocks it with a serial clock, and then raises a latch line to commit the word. All three lines are asynchronous to the system clock. They pass through a synchronizer and an edge detector before any logic uses them. Each committed word holds a register address in its upper bits and a register value in its lower bits.

Two registers are implemented: a power-control register and a general-purpose auxiliary register. The power register holds an off bit for the converter input path (the ADC), one off bit for each stereo output converter (the DACs), and a master off bit. The master bit wins over the individual bits and also disables the reference supply. The block presents both register values and the enables decoded from the power register.

Top module: `ctl3w_port`

## Requirements
- R1: On each rising edge of the serial clock, the port samples the data line and shifts the bit in MSB first. The word that commits is formed by the last 16 bits received before the latch edge, so any earlier bits are discarded.
- R2: A committed word splits into an address in bits 15..9 and a value in bits 8..0. Address 0x1A selects the power register and address 0x05 selects the auxiliary register. The value is written whole into the selected register.
- R3: A word commits only on a rising edge of the latch line. Shifting bits in without a latch edge leaves every output unchanged. A later latch edge with no new bits commits the word already held.
- R4: A word whose address is neither 0x1A nor 0x05 changes no register and no enable.
- R5: Power register bit 0 is the ADC off bit. `adc_en` is low when bit 0 or bit 4 is set, and high otherwise.
- R6: Power register bits 1, 2 and 3 are the off bits for DACs 0, 1 and 2. `dac_en[i]` is low when bit i+1 or bit 4 is set, and high otherwise.
- R7: Power register bit 4 is the master off bit. When it is set, `adc_en`, every `dac_en` bit and `ref_en` are all low, whatever the other bits hold.
- R8: While bit 4 is clear, `ref_en` stays high even if every individual off bit is set.
- R9: After reset, both registers read 0 and every enable, including `ref_en`, is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data line |
| ser_latch | input | 1 | Latch line; a rising edge commits the word |
| pwr_reg | output | 9 | Power-control register contents |
| aux_reg | output | 9 | Auxiliary register contents |
| adc_en | output | 1 | ADC enable |
| dac_en | output | 3 | Per-DAC enables |
| ref_en | output | 1 | Reference supply enable |

## Verification
The bench builds the block with its defaults: a 7-bit address, a 9-bit value, three DACs, a two-stage synchronizer, and the registers at 0x1A and 0x05. With three DACs, every mix of individual and master off bits can be reached, including all individual bits set with the master bit clear. Because the address field is 7 bits wide, a write to an unused address such as 0x33 can be exercised. Serial edges are spaced many system clocks apart, so the synchronizer delay never hides a bit. Words longer than 16 bits and latch edges without fresh bits are also sent.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_PWR, SEL_AUX} reg_sel_e;

  // single-cycle pulse on a low-to-high transition of a synchronized line
  function automatic logic rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {word_q[W-2:0], bit_in};
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
  import ctl3w_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          DATA_W   = 9,
  parameter int          NUM_DAC  = 3,
  parameter logic [6:0]  PWR_ADDR = 7'h1A,
  parameter logic [6:0]  AUX_ADDR = 7'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [DATA_W-1:0]  pwr_q,
  output logic [DATA_W-1:0]  aux_q,
  output logic               adc_en,
  output logic [NUM_DAC-1:0] dac_en,
  output logic               ref_en
);
  localparam int GBIT = NUM_DAC + 1;   // master off bit position

  // enable map {ref, dac[NUM_DAC-1:0], adc}; master bit overrides
  function automatic logic [NUM_DAC+1:0] en_map(input logic [DATA_W-1:0] p);
    logic [NUM_DAC+1:0] m;
    logic g;
    g = p[GBIT];
    m[0] = ~p[0] & ~g;
    for (int i = 0; i < NUM_DAC; i++) m[i+1] = ~p[i+1] & ~g;
    m[NUM_DAC+1] = ~g;
    return m;
  endfunction

  reg_sel_e sel;
  logic [NUM_DAC+1:0] en;

  always_comb begin
    if (addr == ADDR_W'(PWR_ADDR))      sel = SEL_PWR;
    else if (addr == ADDR_W'(AUX_ADDR)) sel = SEL_AUX;
    else                                sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwr_q <= '0;
      aux_q <= '0;
    end else if (commit) begin
      if (sel == SEL_PWR) pwr_q <= data;
      if (sel == SEL_AUX) aux_q <= data;
    end

  assign en     = en_map(pwr_q);
  assign adc_en = en[0];
  assign dac_en = en[NUM_DAC:1];
  assign ref_en = en[NUM_DAC+1];
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 9,
  parameter int          NUM_DAC     = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  PWR_ADDR    = 7'h1A,
  parameter logic [6:0]  AUX_ADDR    = 7'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_latch,
  output logic [DATA_W-1:0]  pwr_reg,
  output logic [DATA_W-1:0]  aux_reg,
  output logic               adc_en,
  output logic [NUM_DAC-1:0] dac_en,
  output logic               ref_en
);
  localparam int W = ADDR_W + DATA_W;

  logic [2:0] sync_q;
  logic sclk_s, sdat_s, latch_s;
  logic sclk_d, latch_d;
  logic shift_pulse, commit;
  logic [W-1:0] word;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  ctl3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_latch, ser_clk, ser_dat}), .q(sync_q)
  );
  assign {latch_s, sclk_s, sdat_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      latch_d <= latch_s;
    end

  assign shift_pulse = rise(sclk_s, sclk_d);
  assign commit      = rise(latch_s, latch_d);

  ctl3w_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_pulse),
    .bit_in(sdat_s), .word_q(word)
  );

  assign addr = word[W-1:DATA_W];
  assign data = word[DATA_W-1:0];

  ctl3w_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DAC(NUM_DAC),
    .PWR_ADDR(PWR_ADDR), .AUX_ADDR(AUX_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .addr(addr), .data(data),
    .pwr_q(pwr_reg), .aux_q(aux_reg),
    .adc_en(adc_en), .dac_en(dac_en), .ref_en(ref_en)
  );
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk #(
  parameter int          ADDR_W   = 7,
  parameter int          DATA_W   = 9,
  parameter int          NUM_DAC  = 3,
  parameter logic [6:0]  PWR_ADDR = 7'h1A,
  parameter logic [6:0]  AUX_ADDR = 7'h05
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      shift_pulse,
  input logic                      commit,
  input logic                      sdat_s,
  input logic [ADDR_W+DATA_W-1:0]  word,
  input logic [DATA_W-1:0]         pwr_reg,
  input logic [DATA_W-1:0]         aux_reg,
  input logic                      adc_en,
  input logic [NUM_DAC-1:0]        dac_en,
  input logic                      ref_en
);
  localparam int W = ADDR_W + DATA_W;
  localparam int GBIT = NUM_DAC + 1;

  a_r1_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> word == {$past(word[W-2:0]), $past(sdat_s)});

  a_r2_pwr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[W-1:DATA_W] == ADDR_W'(PWR_ADDR)) |=> pwr_reg == $past(word[DATA_W-1:0]));

  a_r2_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[W-1:DATA_W] == ADDR_W'(AUX_ADDR)) |=> aux_reg == $past(word[DATA_W-1:0]));

  a_r3_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pwr_reg) && $stable(aux_reg));

  a_r4_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[W-1:DATA_W] != ADDR_W'(PWR_ADDR) && word[W-1:DATA_W] != ADDR_W'(AUX_ADDR))
      |=> $stable(pwr_reg) && $stable(aux_reg));

  a_r5_adc_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_reg[0] && !pwr_reg[GBIT]) |-> adc_en);

  a_r7_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_reg[GBIT] |-> (!adc_en && !ref_en && $countones(dac_en) == 0));

  a_r8_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_reg[GBIT] |-> ref_en);
endmodule

bind ctl3w_port ctl3w_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DAC(NUM_DAC),
  .PWR_ADDR(PWR_ADDR), .AUX_ADDR(AUX_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse), .commit(commit),
  .sdat_s(sdat_s), .word(word), .pwr_reg(pwr_reg), .aux_reg(aux_reg),
  .adc_en(adc_en), .dac_en(dac_en), .ref_en(ref_en)
);

// File: tb/sim_ctl3w_port.sv
module sim_ctl3w_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic [8:0] pwr_reg, aux_reg;
  logic adc_en, ref_en;
  logic [2:0] dac_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [8:0] pwr;
    logic [8:0] aux;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [8:0] m_pwr = '0, m_aux = '0;

  always #2.5 clk = ~clk;

  ctl3w_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_latch(ser_latch), .pwr_reg(pwr_reg), .aux_reg(aux_reg),
    .adc_en(adc_en), .dac_en(dac_en), .ref_en(ref_en)
  );

  task automatic put_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_dat = v[i];
      repeat (5) @(negedge clk); ser_clk = 1'b1;
      repeat (10) @(negedge clk); ser_clk = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic pulse_latch();
    @(negedge clk); ser_latch = 1'b1;
    repeat (10) @(negedge clk); ser_latch = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // reference model update from the requirement text
  task automatic model_commit(input logic [15:0] w);
    if (w[15:9] == 7'h1A) m_pwr = w[8:0];
    else if (w[15:9] == 7'h05) m_aux = w[8:0];
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.pwr = m_pwr; e.aux = m_aux; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic write_word(input logic [6:0] a, input logic [8:0] d, input string tag);
    put_bits({16'h0, a, d}, 16);
    pulse_latch();
    model_commit({a, d});
    expect_now(tag);
  endtask

  // monitor: pops expectations and compares registers and decoded enables
  initial begin
    forever begin
      exp_t e;
      logic g;
      logic [4:0] got, want;
      wait (sb.size() != 0);
      e = sb.pop_front();
      g = e.pwr[4];
      want = {!g, !e.pwr[3] && !g, !e.pwr[2] && !g, !e.pwr[1] && !g, !e.pwr[0] && !g};
      got  = {ref_en, dac_en, adc_en};
      n_chk++;
      if (pwr_reg !== e.pwr || aux_reg !== e.aux || got !== want) begin
        n_fail++;
        $display("FAIL %s: pwr=%h aux=%h en=%b expected pwr=%h aux=%h en=%b",
                 e.tag, pwr_reg, aux_reg, got, e.pwr, e.aux, want);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R9 reset state");

    write_word(7'h1A, 9'h001, "R5 ADC off bit");
    write_word(7'h1A, 9'h00A, "R6 DAC0 and DAC2 off");
    write_word(7'h05, 9'h1A5, "R2 auxiliary write");
    write_word(7'h1A, 9'h00F, "R8 all individual off, reference kept");
    write_word(7'h1A, 9'h010, "R7 master bit alone");
    write_word(7'h1A, 9'h01F, "R7 master with all bits");
    write_word(7'h33, 9'h1FF, "R4 unused address ignored");

    // R3: bits shifted without a latch edge change nothing
    put_bits({16'h0, 7'h05, 9'h0C3}, 16);
    repeat (10) @(negedge clk);
    expect_now("R3 no latch, no change");
    // R3: a bare latch edge commits the word already held
    pulse_latch();
    model_commit({7'h05, 9'h0C3});
    expect_now("R3 latch edge commits held word");

    // R1: leading junk bits are pushed out, last 16 bits count
    put_bits({12'h0, 4'hF, 7'h1A, 9'h004}, 20);
    pulse_latch();
    model_commit({7'h1A, 9'h004});
    expect_now("R1 last 16 bits form the word");

    write_word(7'h1A, 9'h000, "R5 all powered again");
    write_word(7'h1A, 9'h100, "R2 high value bit stored, enables on");

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule